// File: doc/BRIEF.md
# Per-Word Serial Select Regenerator

This block sits between a serial master and a serial-port slave. The master lowers its select once and keeps it low for a whole frame of several words. It marks each word only by running and then halting the serial clock. The slave handles each word as a frame of length one, so it needs a new falling edge on its own select for every word.

The block oversamples the master's select and serial clock in the system clock domain. It counts rising (sampling) edges of the serial clock against a word length given at run time. From that count it drives a separate active-low select to the slave, raising it after each word and lowering it again when the next word starts. The serial clock and both data lines pass straight through. A one-cycle pulse marks each completed word, and a word counter reports how many words the current frame has carried.

The serial clock idles high. Each bit is a falling edge, on which data is launched, followed by a rising edge, on which data is sampled. The master may hold the clock high for any length of time after the last bit of a word, so a word ends by bit count and never by clock timing.

Top module: `spi_word_select_regen`

## Requirements
- R1: After reset, with the master select high, `slvSelN` is high, `wordDone` is 0 and `wordCount` is 0.
- R2: `slvSclk` always equals `mstSclk`, `slvMosi` always equals `mstMosi`, and `mstMiso` always equals `slvMiso`, with no register in the path.
- R3: Whenever `mstSelN` is high, `slvSelN` is high in the same instant, with no system clock edge in between.
- R4: When `mstSelN` falls while the block is idle, `slvSelN` falls in the same instant.
- R5: `slvSelN` stays low until the rising serial clock edge that completes the word. It is high no later than the third system clock edge after that rising edge.
- R6: After a word completes, `slvSelN` stays high for at least 2 system clocks and then until the next falling serial clock edge. A falling edge that arrives during those 2 clocks is remembered and not lost.
- R7: In a frame, `slvSelN` goes low again on the first falling serial clock edge of the next word, at most 3 system clock edges after that edge.
- R8: `wordDone` is high for exactly one system clock per completed word. In that cycle `wordCount` has just incremented by one. `wordCount` clears when a new frame starts and holds its value after the frame ends.
- R9: The word length is taken from `wordLen` once, at frame start. Values below 4 count as 4 and values above 32 count as 32. Changes during a frame have no effect.
- R10: If `mstSelN` rises partway through a word, `slvSelN` rises at once. The partial bit count is discarded, no `wordDone` is produced, and the next frame counts its first word from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| wordLen | input | 6 | Bits per word, taken at frame start and clamped to 4..32 |
| mstSelN | input | 1 | Frame select from the master, active low |
| mstSclk | input | 1 | Serial clock from the master, idles high |
| mstMosi | input | 1 | Data from the master |
| mstMiso | output | 1 | Data returned to the master |
| slvSelN | output | 1 | Per-word select to the slave, active low |
| slvSclk | output | 1 | Serial clock to the slave |
| slvMosi | output | 1 | Data to the slave |
| slvMiso | input | 1 | Data from the slave |
| wordDone | output | 1 | One-cycle pulse at each completed word |
| wordCount | output | 8 | Words completed in the current or last frame |

## Verification
On every cycle, the assertions check four things. The slave select is released whenever the master select is high. Each completion pulse is one cycle long and comes with the released select. The select is still released on the cycle after the pulse. The word counter advances by exactly one at each pulse. Only the bench scenarios can show the rest: that a word ends after the exact bit count taken at frame start, including the clamped lengths and a length change in mid-frame; that the select falls again on the next word's first falling clock edge; that a frame cut short in mid-word leaves no trace in the count; and that the data lines pass through unchanged.

// File: rtl/swsr_pkg.sv
package swsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WORD,
    ST_GAP,
    ST_WAIT
  } regen_state_e;

  typedef struct packed {
    logic startFrame;
    logic clrBits;
    logic incBits;
    logic incWords;
    logic clrHold;
    logic incHold;
    logic setFall;
    logic clrFall;
  } regen_strobe_t;

endpackage

// File: rtl/swsr_sync.sv
module swsr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RST_VAL;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= RST_VAL;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/swsr_datapath.sv
module swsr_datapath
  import swsr_pkg::*;
#(
  parameter int MIN_LEN  = 4,
  parameter int MAX_LEN  = 32,
  parameter int HOLD_MIN = 2,
  parameter int WCNT_W   = 8,
  parameter int SYNC_N   = 2,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int HOLD_W  = $clog2(HOLD_MIN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic              mstSelN,
  input  logic              mstSclk,
  input  regen_strobe_t     strb,
  output logic              selIdle,
  output logic              sclkRise,
  output logic              sclkFall,
  output logic              lastBit,
  output logic              holdDone,
  output logic              fallSeen,
  output logic              wordDone,
  output logic [WCNT_W-1:0] wordCount
);

  logic             selSync;
  logic             sclkSync;
  logic             sclkDly;
  logic [LEN_W-1:0] lenEff;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] bitCnt;
  logic [HOLD_W-1:0] holdCnt;

  swsr_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) i_selSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (mstSelN),
    .dout (selSync)
  );

  swsr_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) i_sclkSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (mstSclk),
    .dout (sclkSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkDly <= 1'b1;
    else       sclkDly <= sclkSync;
  end

  assign selIdle  = selSync;
  assign sclkRise = sclkSync & ~sclkDly;
  assign sclkFall = ~sclkSync & sclkDly;

  // Word length clamped into the supported range
  always_comb begin
    if (wordLen < LEN_W'(MIN_LEN))      lenEff = LEN_W'(MIN_LEN);
    else if (wordLen > LEN_W'(MAX_LEN)) lenEff = LEN_W'(MAX_LEN);
    else                                lenEff = wordLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lenReg <= LEN_W'(MIN_LEN);
    else if (strb.startFrame) lenReg <= lenEff;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCnt <= '0;
    else if (strb.clrBits) bitCnt <= '0;
    else if (strb.incBits) bitCnt <= bitCnt + 1'b1;
  end

  assign lastBit = (bitCnt == lenReg - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdCnt <= '0;
    else if (strb.clrHold) holdCnt <= '0;
    else if (strb.incHold && !holdDone) holdCnt <= holdCnt + 1'b1;
  end

  assign holdDone = (holdCnt == HOLD_W'(HOLD_MIN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             fallSeen <= 1'b0;
    else if (strb.clrFall) fallSeen <= 1'b0;
    else if (strb.setFall) fallSeen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordCount <= '0;
    else if (strb.startFrame) wordCount <= '0;
    else if (strb.incWords)   wordCount <= wordCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordDone <= 1'b0;
    else       wordDone <= strb.incWords;
  end

endmodule

// File: rtl/swsr_control.sv
module swsr_control
  import swsr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          selIdle,
  input  logic          sclkRise,
  input  logic          sclkFall,
  input  logic          lastBit,
  input  logic          holdDone,
  input  logic          fallSeen,
  output regen_strobe_t strb,
  output logic          gapActive
);

  regen_state_e state;
  regen_state_e stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (!selIdle) begin
          stateNext       = ST_WORD;
          strb.startFrame = 1'b1;
          strb.clrBits    = 1'b1;
        end
      end
      ST_WORD: begin
        if (selIdle) begin
          stateNext = ST_IDLE;
        end else if (sclkRise) begin
          if (lastBit) begin
            stateNext     = ST_GAP;
            strb.incWords = 1'b1;
            strb.clrHold  = 1'b1;
            strb.clrFall  = 1'b1;
          end else begin
            strb.incBits = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (selIdle) begin
          stateNext = ST_IDLE;
        end else begin
          strb.incHold = 1'b1;
          if (sclkFall) strb.setFall = 1'b1;
          if (holdDone) stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (selIdle) begin
          stateNext = ST_IDLE;
        end else if (sclkFall || fallSeen) begin
          stateNext    = ST_WORD;
          strb.clrBits = 1'b1;
          strb.clrFall = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign gapActive = (state == ST_GAP) || (state == ST_WAIT);

endmodule

// File: rtl/spi_word_select_regen.sv
module spi_word_select_regen
  import swsr_pkg::*;
#(
  parameter int MIN_LEN  = 4,
  parameter int MAX_LEN  = 32,
  parameter int HOLD_MIN = 2,
  parameter int WCNT_W   = 8,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  wordLen,
  input  logic              mstSelN,
  input  logic              mstSclk,
  input  logic              mstMosi,
  output logic              mstMiso,
  output logic              slvSelN,
  output logic              slvSclk,
  output logic              slvMosi,
  input  logic              slvMiso,
  output logic              wordDone,
  output logic [WCNT_W-1:0] wordCount
);

  regen_strobe_t strb;
  logic selIdle;
  logic sclkRise;
  logic sclkFall;
  logic lastBit;
  logic holdDone;
  logic fallSeen;
  logic gapActive;

  swsr_datapath #(
    .MIN_LEN  (MIN_LEN),
    .MAX_LEN  (MAX_LEN),
    .HOLD_MIN (HOLD_MIN),
    .WCNT_W   (WCNT_W),
    .SYNC_N   (2)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .wordLen   (wordLen),
    .mstSelN   (mstSelN),
    .mstSclk   (mstSclk),
    .strb      (strb),
    .selIdle   (selIdle),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .lastBit   (lastBit),
    .holdDone  (holdDone),
    .fallSeen  (fallSeen),
    .wordDone  (wordDone),
    .wordCount (wordCount)
  );

  swsr_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .selIdle   (selIdle),
    .sclkRise  (sclkRise),
    .sclkFall  (sclkFall),
    .lastBit   (lastBit),
    .holdDone  (holdDone),
    .fallSeen  (fallSeen),
    .strb      (strb),
    .gapActive (gapActive)
  );

  // Raw master select gives immediate assert and immediate release
  assign slvSelN = mstSelN | gapActive;
  assign slvSclk = mstSclk;
  assign slvMosi = mstMosi;
  assign mstMiso = slvMiso;

endmodule

// File: rtl/swsr_checker.sv
module swsr_checker #(
  parameter int WCNT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              mstSelN,
  input logic              slvSelN,
  input logic              wordDone,
  input logic [WCNT_W-1:0] wordCount
);

  assert_sel_released_R3: assert property (@(posedge clk) disable iff (!rstN)
    mstSelN |-> slvSelN);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> !wordDone);

  assert_done_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> (wordCount == WCNT_W'($past(wordCount) + 1'b1)));

  assert_done_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |-> slvSelN);

  assert_gap_min_R6: assert property (@(posedge clk) disable iff (!rstN)
    wordDone |=> slvSelN);

endmodule

bind spi_word_select_regen swsr_checker #(.WCNT_W(WCNT_W)) i_swsrChecker (
  .clk       (clk),
  .rstN      (rstN),
  .mstSelN   (mstSelN),
  .slvSelN   (slvSelN),
  .wordDone  (wordDone),
  .wordCount (wordCount)
);

// File: tb/test_spi_word_select_regen.sv
module test_spi_word_select_regen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] wordLen = 6'd16;
  logic       mstSelN = 1'b1;
  logic       mstSclk = 1'b1;
  logic       mstMosi = 1'b0;
  logic       mstMiso;
  logic       slvSelN;
  logic       slvSclk;
  logic       slvMosi;
  logic       slvMiso = 1'b0;
  logic       wordDone;
  logic [7:0] wordCount;

  int chkCnt = 0;
  int errCnt = 0;
  int expQ[$];

  always #2 clk = ~clk;

  spi_word_select_regen i_spi_word_select_regen (
    .clk       (clk),
    .rstN      (rstN),
    .wordLen   (wordLen),
    .mstSelN   (mstSelN),
    .mstSclk   (mstSclk),
    .mstMosi   (mstMosi),
    .mstMiso   (mstMiso),
    .slvSelN   (slvSelN),
    .slvSclk   (slvSclk),
    .slvMosi   (slvMosi),
    .slvMiso   (slvMiso),
    .wordDone  (wordDone),
    .wordCount (wordCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effLen(input int l);
    if (l < 4) return 4;
    if (l > 32) return 32;
    return l;
  endfunction

  // Monitor: pops the expected word count at every completion pulse
  always @(negedge clk) begin
    if (rstN && wordDone) begin
      chkCnt++;
      if (expQ.size() == 0) begin
        errCnt++;
        $display("FAIL R8 unexpected wordDone actual=%0d expected=none", wordCount);
      end else begin
        int e;
        e = expQ.pop_front();
        if (int'(wordCount) != e) begin
          errCnt++;
          $display("FAIL R8 wordCount at wordDone actual=%0d expected=%0d", wordCount, e);
        end
      end
    end
  end

  task automatic sendFrame(input int lenIn, input int nWords, input int stretch,
                           input bit changeLen);
    int len;
    len = effLen(lenIn);
    @(negedge clk);
    wordLen = 6'(lenIn);
    mstSelN = 1'b0;
    #1 chk("R4 select falls with master", int'(slvSelN), 0);
    repeat (4) @(negedge clk);
    for (int w = 0; w < nWords; w++) begin
      for (int b = 0; b < len; b++) begin
        mstSclk = 1'b0;
        mstMosi = b[0] ^ w[0];
        slvMiso = ~b[1];
        #1;
        chk("R2 sclk pass", int'(slvSclk), 0);
        chk("R2 mosi pass", int'(slvMosi), int'(mstMosi));
        chk("R2 miso pass", int'(mstMiso), int'(slvMiso));
        repeat (4) @(negedge clk);
        if (b == 0 && w > 0) chk("R7 select re-asserted", int'(slvSelN), 0);
        if (b == len - 1) chk("R5 select low before last bit", int'(slvSelN), 0);
        if (changeLen && w == 0 && b == 1) wordLen = 6'd4;  // R9 ignored mid-frame
        mstSclk = 1'b1;
        if (b == len - 1) begin
          expQ.push_back(w + 1);
          repeat (4) @(negedge clk);
          chk("R5 select high after word", int'(slvSelN), 1);
          repeat (stretch) @(negedge clk);
          chk("R6 select held high in gap", int'(slvSelN), 1);
        end else begin
          repeat (4) @(negedge clk);
        end
      end
    end
    mstSelN = 1'b1;
    #1 chk("R3 select high with master", int'(slvSelN), 1);
    repeat (8) @(negedge clk);
    chk("R8 wordCount held after frame", int'(wordCount), nWords);
    chk("R8 all expected words seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset select", int'(slvSelN), 1);
    chk("R1 reset wordDone", int'(wordDone), 0);
    chk("R1 reset wordCount", int'(wordCount), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle select", int'(slvSelN), 1);

    sendFrame(16, 8, 6, 1'b0);
    sendFrame(8, 3, 2, 1'b1);     // R9 mid-frame length change ignored
    sendFrame(2, 2, 10, 1'b0);    // R9 clamp to 4
    sendFrame(40, 1, 3, 1'b0);    // R9 clamp to 32

    // R10 abort partway through a word
    @(negedge clk);
    wordLen = 6'd8;
    mstSelN = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      mstSclk = 1'b0;
      repeat (4) @(negedge clk);
      mstSclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    mstSelN = 1'b1;
    #1 chk("R10 select released on abort", int'(slvSelN), 1);
    repeat (8) @(negedge clk);
    chk("R10 no word counted on abort", int'(wordCount), 0);

    // Fresh frame after abort: count must start at zero
    sendFrame(5, 2, 4, 1'b0);
    @(negedge clk);
    mstSelN = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 wordCount cleared at frame start", int'(wordCount), 0);
    mstSelN = 1'b1;
    repeat (8) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule